// File: doc/BRIEF.md
# TLB-Backed Page Address Translator

This block converts a processor's logical byte address into a physical address for a single-level paged memory. It splits the incoming address into a page number and an in-page offset. It then compares the page number and the requesting process's address-space tag against every entry of a small fully associative translation cache at once. A match produces the frame number with no memory traffic. On a miss, the block first tests the page number against a table-length bound. If the page number is in range, it issues one read to the in-memory page table at `tableBase + 4*pageNumber`. It checks the valid flag of the returned entry and, when the flag is set, loads that entry into the cache.

One translation is in flight at a time. A request is accepted through a valid/ready pair, and the result comes back as a single-cycle `doneValid` strobe. That strobe carries the physical address and, where a fault occurred, a flag giving its cause. The `flush` input empties the whole cache in one cycle, for example on an address-space switch. Page size, address widths, tag width and cache depth are all parameters. The page size must be a power of two from 512 to 8192 bytes.

Top module: `pgx_translator`

## Requirements
- R1: `reqReady` is high only while no translation is in flight. A request is taken at a rising edge where `reqValid` and `reqReady` are both high. `reqReady` is then low from the next cycle until the cycle in which `doneValid` is high, and it is high again in that cycle.
- R2: The page number is `reqAddr[LA_W-1:PAGE_BITS]` and the offset is `reqAddr[PAGE_BITS-1:0]`. A successful translation returns `donePhys = {frame, offset}`, with the offset unchanged.
- R3: A hit needs a valid cache entry whose page number and address-space tag both equal the request's. On a hit, `doneValid` and `doneHit` are high in the cycle after the second rising edge following acceptance, and no memory read is issued.
- R4: On a miss with an in-range page number, `memReqValid` is high for exactly one cycle: the cycle after the second rising edge following acceptance. In that cycle `memReqAddr = ptBase + 4*pageNumber`.
- R5: A page-table entry holds its valid flag in bit 31 and its frame number in bits 19:0. When `memRspValid` is sampled at an edge and the flag is set, `doneValid` follows that edge with `doneHit=0` and the physical address from the fetched frame, and the entry is loaded into the cache.
- R6: A miss whose page number is greater than or equal to `ptLen` completes with `faultRange=1` and `donePhys=0`, with the same timing as a hit and no memory read. Pages already in the cache hit regardless of `ptLen`.
- R7: A fetched entry whose valid flag is clear completes with `faultInvalid=1` and `donePhys=0`. It is never cached, so a repeat of the same address misses and reads memory again.
- R8: An entry loaded under one address-space tag does not hit for a request carrying a different tag. At most one entry matches any request.
- R9: Refills fill cache slots in round-robin order starting at slot 0. With 8 entries, the ninth refill replaces the first page loaded.
- R10: `flush` high at a rising edge invalidates every entry and returns the replacement order to slot 0. The next lookup misses.
- R11: `doneHit`, `faultRange` and `faultInvalid` are high only together with `doneValid`, and at most one of them is high at a time.
- R12: After reset, `reqReady=1`, `doneValid=0`, `memReqValid=0`, and the cache holds no valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all cache entries |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block idle, request can be taken |
| reqAddr | input | LA_W | Logical address |
| reqAsid | input | ASID_W | Address-space tag of the requester |
| ptBase | input | FRAME_W+PAGE_BITS | Byte address of the page table |
| ptLen | input | LA_W-PAGE_BITS+1 | Number of entries in the page table |
| memReqValid | output | 1 | Page-table read strobe, one cycle |
| memReqAddr | output | FRAME_W+PAGE_BITS | Page-table entry address |
| memRspValid | input | 1 | Read data present |
| memRspData | input | PTE_W | Page-table entry read back |
| doneValid | output | 1 | Result strobe, one cycle |
| donePhys | output | FRAME_W+PAGE_BITS | Physical address, zero on a fault |
| doneHit | output | 1 | Result came from the cache |
| faultRange | output | 1 | Page number beyond the table length |
| faultInvalid | output | 1 | Page-table entry not valid |

## Verification
Hits and range faults complete two edges after acceptance. A miss raises its read strobe at that same point, and a walk completes one edge after the response is sampled. The bench steps each request edge by edge. It samples at the falling edge that follows the edge where each result is due, and at the neighbouring cycles it checks that the strobes are low. Its behavioural cache model, which includes round-robin slot order and flush, predicts for every request whether a read must appear. Every falling edge also checks the flag-only-with-strobe rule.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;
    logic issueRead;
    logic refill;
    logic doneHit;
    logic doneWalk;
    logic faultRange;
    logic faultInvalid;
  } xlat_ctl_t;

  // Conditions reported back to the control FSM
  typedef struct packed {
    logic hit;
    logic outOfRange;
    logic pteValid;
  } xlat_sts_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_WALK   = 2'd2
  } xlat_state_e;

endpackage

// File: rtl/pgx_tlb.sv
module pgx_tlb #(
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 20,
  parameter int ASID_W  = 8,
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lookVpn,
  input  logic [ASID_W-1:0]  lookAsid,
  output logic               hit,
  output logic [FRAME_W-1:0] hitFrame,
  input  logic               refill,
  input  logic [FRAME_W-1:0] refillFrame
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] matchVec;
  logic [VPN_W-1:0]   entVpn   [ENTRIES];
  logic [ASID_W-1:0]  entAsid  [ENTRIES];
  logic [FRAME_W-1:0] entFrame [ENTRIES];
  logic [IDX_W-1:0]   victim;

  // Parallel compare of every entry
  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
      assign matchVec[g] = entValid[g] && (entVpn[g] == lookVpn) && (entAsid[g] == lookAsid);
    end
  endgenerate

  assign hit = |matchVec;

  always_comb begin
    hitFrame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) hitFrame = hitFrame | entFrame[i];
    end
  end

  // Entry storage: flush wins over a refill at the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entVpn[i]   <= '0;
        entAsid[i]  <= '0;
        entFrame[i] <= '0;
      end
    end else if (flush) begin
      entValid <= '0;
    end else if (refill) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (victim == IDX_W'(i)) begin
          entValid[i] <= 1'b1;
          entVpn[i]   <= lookVpn;
          entAsid[i]  <= lookAsid;
          entFrame[i] <= refillFrame;
        end
      end
    end
  end

  // Round-robin victim pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victim <= '0;
    end else if (flush) begin
      victim <= '0;
    end else if (refill) begin
      victim <= (victim == LAST_IDX) ? '0 : victim + 1'b1;
    end
  end

  assert_single_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !hit);

  assert_refill_on_miss_R9: assert property (@(posedge clk) disable iff (!rstN)
    refill |-> !hit);

endmodule

// File: rtl/pgx_datapath.sv
module pgx_datapath
  import pgx_pkg::*;
#(
  parameter int LA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int FRAME_W   = 20,
  parameter int ASID_W    = 8,
  parameter int ENTRIES   = 8,
  parameter int PTE_W     = 32,
  localparam int VPN_W    = LA_W - PAGE_BITS,
  localparam int PHYS_W   = FRAME_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic [LA_W-1:0]   reqAddr,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic [PHYS_W-1:0] ptBase,
  input  logic [VPN_W:0]    ptLen,
  input  logic              memRspValid,
  input  logic [PTE_W-1:0]  memRspData,
  input  xlat_ctl_t         ctl,
  output xlat_sts_t         sts,
  output logic              memReqValid,
  output logic [PHYS_W-1:0] memReqAddr,
  output logic              doneValid,
  output logic [PHYS_W-1:0] donePhys,
  output logic              doneHit,
  output logic              faultRange,
  output logic              faultInvalid
);

  localparam int PTE_BYTES_LOG2 = 2;

  logic [VPN_W-1:0]     curVpn;
  logic [PAGE_BITS-1:0] curOff;
  logic [ASID_W-1:0]    curAsid;
  logic [FRAME_W-1:0]   tlbFrame;
  logic [FRAME_W-1:0]   pteFrame;
  logic                 tlbHit;
  logic                 unusedPteBits;

  assign pteFrame      = memRspData[FRAME_W-1:0];
  assign unusedPteBits = ^memRspData[PTE_W-2:FRAME_W];

  assign sts.hit        = tlbHit;
  assign sts.outOfRange = ({1'b0, curVpn} >= ptLen);
  assign sts.pteValid   = memRspData[PTE_W-1];

  pgx_tlb #(
    .VPN_W  (VPN_W),
    .FRAME_W(FRAME_W),
    .ASID_W (ASID_W),
    .ENTRIES(ENTRIES)
  ) u_tlb (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .lookVpn    (curVpn),
    .lookAsid   (curAsid),
    .hit        (tlbHit),
    .hitFrame   (tlbFrame),
    .refill     (ctl.refill),
    .refillFrame(pteFrame)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curVpn       <= '0;
      curOff       <= '0;
      curAsid      <= '0;
      memReqValid  <= 1'b0;
      memReqAddr   <= '0;
      doneValid    <= 1'b0;
      donePhys     <= '0;
      doneHit      <= 1'b0;
      faultRange   <= 1'b0;
      faultInvalid <= 1'b0;
    end else begin
      if (ctl.capture) begin
        curVpn  <= reqAddr[LA_W-1:PAGE_BITS];
        curOff  <= reqAddr[PAGE_BITS-1:0];
        curAsid <= reqAsid;
      end
      memReqValid <= ctl.issueRead;
      if (ctl.issueRead) begin
        memReqAddr <= ptBase + PHYS_W'({curVpn, {PTE_BYTES_LOG2{1'b0}}});
      end
      doneValid    <= ctl.doneHit | ctl.doneWalk | ctl.faultRange | ctl.faultInvalid;
      doneHit      <= ctl.doneHit;
      faultRange   <= ctl.faultRange;
      faultInvalid <= ctl.faultInvalid;
      if (ctl.doneHit) begin
        donePhys <= {tlbFrame, curOff};
      end else if (ctl.doneWalk) begin
        donePhys <= {pteFrame, curOff};
      end else if (ctl.faultRange || ctl.faultInvalid) begin
        donePhys <= '0;
      end
    end
  end

  assert_no_read_on_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !$past(tlbHit));

  assert_single_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  assert_refill_valid_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.refill |-> (memRspValid && memRspData[PTE_W-1]));

  assert_flags_with_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    (doneHit || faultRange || faultInvalid) |-> doneValid);

  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({doneHit, faultRange, faultInvalid}));

endmodule

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
  import pgx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      memRspValid,
  input  xlat_sts_t sts,
  output logic      reqReady,
  output xlat_ctl_t ctl
);

  xlat_state_e state, nextState;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.capture = 1'b1;
          nextState   = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (sts.hit) begin
          ctl.doneHit = 1'b1;
          nextState   = ST_IDLE;
        end else if (sts.outOfRange) begin
          ctl.faultRange = 1'b1;
          nextState      = ST_IDLE;
        end else begin
          ctl.issueRead = 1'b1;
          nextState     = ST_WALK;
        end
      end
      ST_WALK: begin
        if (memRspValid) begin
          if (sts.pteValid) begin
            ctl.refill   = 1'b1;
            ctl.doneWalk = 1'b1;
          end else begin
            ctl.faultInvalid = 1'b1;
          end
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_walk_waits_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WALK && !memRspValid) |=> !reqReady);

endmodule

// File: rtl/pgx_translator.sv
module pgx_translator #(
  parameter int LA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int FRAME_W   = 20,
  parameter int ASID_W    = 8,
  parameter int ENTRIES   = 8,
  parameter int PTE_W     = 32,
  localparam int VPN_W    = LA_W - PAGE_BITS,
  localparam int PHYS_W   = FRAME_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [LA_W-1:0]   reqAddr,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic [PHYS_W-1:0] ptBase,
  input  logic [VPN_W:0]    ptLen,
  output logic              memReqValid,
  output logic [PHYS_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [PTE_W-1:0]  memRspData,
  output logic              doneValid,
  output logic [PHYS_W-1:0] donePhys,
  output logic              doneHit,
  output logic              faultRange,
  output logic              faultInvalid
);

  pgx_pkg::xlat_ctl_t ctl;
  pgx_pkg::xlat_sts_t sts;

  pgx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memRspValid(memRspValid),
    .sts        (sts),
    .reqReady   (reqReady),
    .ctl        (ctl)
  );

  pgx_datapath #(
    .LA_W     (LA_W),
    .PAGE_BITS(PAGE_BITS),
    .FRAME_W  (FRAME_W),
    .ASID_W   (ASID_W),
    .ENTRIES  (ENTRIES),
    .PTE_W    (PTE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .flush       (flush),
    .reqAddr     (reqAddr),
    .reqAsid     (reqAsid),
    .ptBase      (ptBase),
    .ptLen       (ptLen),
    .memRspValid (memRspValid),
    .memRspData  (memRspData),
    .ctl         (ctl),
    .sts         (sts),
    .memReqValid (memReqValid),
    .memReqAddr  (memReqAddr),
    .doneValid   (doneValid),
    .donePhys    (donePhys),
    .doneHit     (doneHit),
    .faultRange  (faultRange),
    .faultInvalid(faultInvalid)
  );

endmodule

// File: tb/pgx_translator_tb.sv
`timescale 1ns/1ps
module pgx_translator_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [7:0]  reqAsid = '0;
  logic [31:0] ptBase = '0;
  logic [20:0] ptLen = '0;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        doneValid;
  logic [31:0] donePhys;
  logic        doneHit;
  logic        faultRange;
  logic        faultInvalid;

  always #2 clk = ~clk;

  pgx_translator u_dut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqAsid(reqAsid),
    .ptBase(ptBase), .ptLen(ptLen),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .doneValid(doneValid), .donePhys(donePhys), .doneHit(doneHit),
    .faultRange(faultRange), .faultInvalid(faultInvalid)
  );

  int vectors = 0;
  int fails = 0;
  int ptLenInt = 0;

  // Bench-side page table and cache model
  logic [31:0] pteMem [64];
  int  mVpn [8];
  int  mAsid [8];
  int  mFrame [8];
  bit  mValid [8];
  int  mPtr = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelFlush();
    for (int i = 0; i < 8; i++) mValid[i] = 1'b0;
    mPtr = 0;
  endtask

  task automatic xlat(input int vpn, input int off, input int asid);
    logic [31:0] pte;
    logic [31:0] expPhys;
    int idx;
    idx = -1;
    for (int i = 0; i < 8; i++)
      if (mValid[i] && mVpn[i] == vpn && mAsid[i] == asid) idx = i;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready while idle", 32'(reqReady), 32'd1);
    reqValid = 1'b1;
    reqAddr  = {vpn[19:0], off[11:0]};
    reqAsid  = asid[7:0];
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R1 busy after accept", 32'(reqReady), 32'd0);
    chk(doneValid == 1'b0, "R3 no early result", 32'(doneValid), 32'd0);
    if (idx >= 0 || vpn >= ptLenInt) begin
      @(posedge clk);
      @(negedge clk);
      chk(doneValid == 1'b1, "R3 result due", 32'(doneValid), 32'd1);
      chk(memReqValid == 1'b0, "R3 no read on hit or range fault", 32'(memReqValid), 32'd0);
      chk(reqReady == 1'b1, "R1 ready with result", 32'(reqReady), 32'd1);
      if (idx >= 0) begin
        expPhys = {mFrame[idx][19:0], off[11:0]};
        chk(doneHit == 1'b1, "R3 hit flag", 32'(doneHit), 32'd1);
        chk(donePhys == expPhys, "R2 hit address", donePhys, expPhys);
      end else begin
        chk(faultRange == 1'b1, "R6 range fault", 32'(faultRange), 32'd1);
        chk(donePhys == 32'd0, "R6 zero address", donePhys, 32'd0);
      end
    end else begin
      @(posedge clk);
      @(negedge clk);
      chk(memReqValid == 1'b1, "R4 read strobe", 32'(memReqValid), 32'd1);
      chk(memReqAddr == ptBase + 32'(vpn * 4), "R4 read address", memReqAddr, ptBase + 32'(vpn * 4));
      chk(doneValid == 1'b0, "R4 no result yet", 32'(doneValid), 32'd0);
      @(negedge clk);
      chk(memReqValid == 1'b0, "R4 single strobe", 32'(memReqValid), 32'd0);
      chk(doneValid == 1'b0, "R5 waits for data", 32'(doneValid), 32'd0);
      pte = pteMem[vpn];
      memRspValid = 1'b1;
      memRspData  = pte;
      @(posedge clk);
      @(negedge clk);
      memRspValid = 1'b0;
      memRspData  = '0;
      chk(doneValid == 1'b1, "R5 walk result", 32'(doneValid), 32'd1);
      chk(doneHit == 1'b0, "R5 not a hit", 32'(doneHit), 32'd0);
      if (pte[31]) begin
        expPhys = {pte[19:0], off[11:0]};
        chk(donePhys == expPhys, "R2 walk address", donePhys, expPhys);
        chk(faultInvalid == 1'b0, "R5 no fault", 32'(faultInvalid), 32'd0);
        mVpn[mPtr] = vpn; mAsid[mPtr] = asid; mFrame[mPtr] = int'(pte[19:0]);
        mValid[mPtr] = 1'b1;
        mPtr = (mPtr + 1) % 8;
      end else begin
        chk(faultInvalid == 1'b1, "R7 invalid fault", 32'(faultInvalid), 32'd1);
        chk(donePhys == 32'd0, "R7 zero address", donePhys, 32'd0);
      end
    end
  endtask

  // Every-cycle rule on the result flags
  always @(negedge clk) begin
    if (rstN) begin
      if (!doneValid)
        chk(!(doneHit || faultRange || faultInvalid), "R11 flag without result",
            {29'd0, doneHit, faultRange, faultInvalid}, 32'd0);
      else
        chk($countones({doneHit, faultRange, faultInvalid}) <= 1, "R11 flags exclusive",
            {29'd0, doneHit, faultRange, faultInvalid}, 32'd1);
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      pteMem[i] = {((i % 5) != 3), 11'd0, 20'(32'h100 + i * 7)};
    end
    modelFlush();
    ptBase   = 32'h0001_0000;
    ptLenInt = 40;
    ptLen    = 21'(ptLenInt);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(reqReady == 1'b1, "R12 ready after reset", 32'(reqReady), 32'd1);
    chk(doneValid == 1'b0, "R12 no result after reset", 32'(doneValid), 32'd0);
    chk(memReqValid == 1'b0, "R12 no read after reset", 32'(memReqValid), 32'd0);
    rstN = 1'b1;

    xlat(1, 'h123, 3);                      // R5 first walk, R12 empty cache
    xlat(1, 'h7ff, 3);
    chk(doneHit == 1'b1, "R3 second access hits", 32'(doneHit), 32'd1);
    xlat(1, 'h456, 4);
    chk(doneHit == 1'b0, "R8 other tag misses", 32'(doneHit), 32'd0);
    xlat(1, 'h001, 3);
    chk(doneHit == 1'b1, "R8 original tag still hits", 32'(doneHit), 32'd1);

    xlat(3, 'h010, 3);                      // invalid entry
    xlat(3, 'h020, 3);
    chk(faultInvalid == 1'b1, "R7 invalid entry not cached", 32'(faultInvalid), 32'd1);

    xlat(40, 'h000, 3);
    chk(faultRange == 1'b1, "R6 page equal to length", 32'(faultRange), 32'd1);
    xlat(45, 'hfff, 3);
    xlat(39, 'habc, 3);
    xlat(39, 'h000, 3);
    chk(doneHit == 1'b1, "R2 last legal page hits", 32'(doneHit), 32'd1);

    xlat(5, 'h111, 3);
    xlat(6, 'h222, 3);
    xlat(7, 'h333, 3);
    xlat(9, 'h444, 3);
    xlat(10, 'h555, 3);
    xlat(11, 'h666, 3);                     // ninth refill, slot 0 again
    xlat(1, 'h010, 3);
    chk(doneHit == 1'b0, "R9 oldest page evicted", 32'(doneHit), 32'd0);
    xlat(6, 'h020, 3);
    chk(doneHit == 1'b1, "R9 younger page kept", 32'(doneHit), 32'd1);

    ptLenInt = 4;
    ptLen    = 21'(ptLenInt);
    xlat(6, 'h030, 3);
    chk(doneHit == 1'b1, "R6 cached page ignores length", 32'(doneHit), 32'd1);
    ptLenInt = 40;
    ptLen    = 21'(ptLenInt);

    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0;
    modelFlush();
    xlat(6, 'h040, 3);
    chk(doneHit == 1'b0, "R10 miss after flush", 32'(doneHit), 32'd0);
    xlat(6, 'h050, 3);
    chk(doneHit == 1'b1, "R10 refill after flush", 32'(doneHit), 32'd1);

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule